// File: doc/BRIEF.md
# BCH8 Sector Error Fixer

This block handles the data side of decoding one 512-byte sector protected by an 8-bit-correcting BCH code. It takes the parity result bytes captured by the encoder hardware and reorders them into the stored ECC byte layout. It also reverses them into the syndrome byte order that an external error locator expects. A separate solver produces a list of error bit positions from that syndrome. This block turns each position into a byte address and a bit mask, then flips that bit in an external sector buffer through a byte-wide read-modify-write port.

A run begins with a one-cycle `start` pulse while the block is idle. If the stored spare-area ECC bytes are all 0xFF, the sector is treated as freshly erased and nothing is touched. If the locator reports the sector as uncorrectable, or gives a count above eight, the run ends with a failure status and no buffer access. Otherwise each listed location is handled in list order. Locations inside the parity region, and locations beyond the data region, are skipped. The run ends with a one-cycle `done`, an `ok` status and the number of bits flipped.

The state machine has five states:

- IDLE waits for `start`. It goes to DONE when the sector is erased (E1), when the locator fails (E2) or when the count is over eight (E3). Otherwise it goes to PICK (T1).
- PICK looks at entry `idx`. It goes to DONE when all entries are used (T2), to READ when the location maps into data (T3), and stays in PICK while skipping an entry (T4).
- READ issues the buffer read and always moves on to WRITE (T5).
- WRITE writes the byte back with the bit flipped and returns to PICK (T6).
- DONE shows the result for one cycle and returns to IDLE (T7).

Top module: `bch8_fixer`

## Requirements
- R1: `calc_bytes` byte k sits at bits [8k+7:8k]. Byte 0 is the low byte of result register 3. Bytes 1..4 are register 2, bytes 5..8 are register 1 and bytes 9..12 are register 0, each register taken from its most significant byte down. Byte 13 is always zero. In `res_bytes`, register 0 is bits [31:0], register 1 is [63:32], register 2 is [95:64] and the low byte of register 3 is [103:96].
- R2: `syndrome` byte i (bits [8i+7:8i]) equals `calc_bytes` byte 12−i, for i = 0..12.
- R3: If all 14 bytes of `spare_ecc` are 0xFF when `start` is accepted, `done` rises one cycle later with `ok`=1, `fix_count`=0 and no buffer access.
- R4: If `loc_fail` is 1, or `loc_count` is above 8, and the sector is not erased, `done` rises one cycle later with `ok`=0, `fix_count`=0 and no buffer access.
- R5: A location of 103 or less (parity region), or of 4200 or more (past the data), changes nothing and costs one cycle.
- R6: For a location p from 104 to 4199, let L = p−104. The byte address is (4095−L)/8 and the mask is 1 shifted left by L mod 8.
- R7: Entries 0..`loc_count`−1 of `loc_list` (13 bits each, entry e at bits [13e+12:13e]) are handled in order. Each fix is a read with `buf_rd_en`, the read data arriving on `buf_rdata` one cycle later, then a write of that data XOR the mask to the same address in the next cycle. Entries at or beyond the count are not used.
- R8: On a normal run, `done` comes 2 + S + 3F cycles after the `start` edge, where S is the number of skipped entries and F the number of fixes. At that point `ok`=1 and `fix_count`=F.
- R9: `start` is acted on only in IDLE. The location inputs are captured when a run starts. `done` lasts exactly one cycle, `busy` is high from the cycle after `start` until the cycle after `done`, and a read and a write never happen in the same cycle.
- R10: After reset the block is idle: `busy`, `done`, `ok`, `buf_rd_en` and `buf_wr_en` are 0 and `fix_count` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to process the sector |
| res_bytes | input | 104 | Parity result registers 0..2 and the low byte of register 3 |
| spare_ecc | input | 112 | ECC bytes read from the spare area, byte k at [8k+7:8k] |
| loc_count | input | 4 | Number of error locations from the locator |
| loc_list | input | 104 | Eight 13-bit error bit locations |
| loc_fail | input | 1 | Locator reports the sector as uncorrectable |
| calc_bytes | output | 112 | Computed ECC bytes in stored order |
| syndrome | output | 104 | Byte-reversed syndrome for the locator |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Status of the last run (1 = good) |
| fix_count | output | 4 | Bits flipped in the last run |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd_en | output | 1 | Sector buffer read strobe |
| buf_rdata | input | 8 | Read data, valid one cycle after the strobe |
| buf_wr_en | output | 1 | Sector buffer write strobe |
| buf_wdata | output | 8 | Corrected byte to write |

## Verification
The bench targets the edges of the location window: 103 against 104, and 4199 against 4200. Getting either edge wrong corrupts a byte that should stay intact, or leaves an error uncorrected at byte 511 or byte 0. Two fixes inside one byte check that the second read sees the first write; a pipeline that reused stale data would lose the first flip. Erased sectors, a locator failure with valid-looking locations, and a count of nine must cause no writes at all; a design that checked them in the wrong order or too late would write to the buffer or report the wrong status. A second `start` and altered locations during a run check that the inputs are captured only when a run starts; a design that missed this would process garbage or start a second run.

// File: rtl/bch8_fix_pkg.sv
package bch8_fix_pkg;
    localparam int DEF_SECTOR_BYTES   = 512;
    localparam int DEF_PARITY_NIBBLES = 26;
    localparam int DEF_MAX_ERRS       = 8;
    localparam int DEF_LOC_W          = 13;
    localparam int DEF_CNT_W          = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } fix_state_t;
endpackage

// File: rtl/bch8_result_order.sv
module bch8_result_order #(
    parameter int SYN_BYTES = 13,
    parameter int ECC_BYTES = 14
) (
    input  logic [8*SYN_BYTES-1:0] res_bytes,
    output logic [8*ECC_BYTES-1:0] calc_bytes,
    output logic [8*SYN_BYTES-1:0] syndrome
);
    // Stored order reads the top result byte first; the syndrome is its mirror.
    for (genvar i = 0; i < SYN_BYTES; i++) begin : g_byte
        assign syndrome[8*i +: 8]   = res_bytes[8*i +: 8];
        assign calc_bytes[8*i +: 8] = res_bytes[8*(SYN_BYTES-1-i) +: 8];
    end
    for (genvar k = SYN_BYTES; k < ECC_BYTES; k++) begin : g_pad
        assign calc_bytes[8*k +: 8] = 8'h00;
    end
endmodule

// File: rtl/bch8_erase_detect.sv
module bch8_erase_detect #(
    parameter int ECC_BYTES = 14
) (
    input  logic [8*ECC_BYTES-1:0] spare_ecc,
    output logic                   erased
);
    assign erased = &spare_ecc;
endmodule

// File: rtl/bch8_loc_map.sv
module bch8_loc_map #(
    parameter int LOC_W       = 13,
    parameter int PARITY_BITS = 104,
    parameter int DATA_BITS   = 4096,
    parameter int ADDR_W      = 9
) (
    input  logic [LOC_W-1:0]  loc,
    output logic              hit,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        mask
);
    localparam int BIT_W = $clog2(DATA_BITS);
    localparam logic [LOC_W-1:0] LAST_PAR = LOC_W'(PARITY_BITS - 1);
    localparam logic [LOC_W:0]   SPAN     = (LOC_W+1)'(DATA_BITS);

    logic [LOC_W-1:0] rel;
    logic [BIT_W-1:0] pos;

    assign rel  = loc - LOC_W'(PARITY_BITS);
    assign hit  = (loc > LAST_PAR) && ({1'b0, rel} < SPAN);
    assign pos  = BIT_W'(DATA_BITS - 1) - rel[BIT_W-1:0];
    assign addr = pos[BIT_W-1:3];
    assign mask = 8'(1) << rel[2:0];
endmodule

// File: rtl/bch8_fixer.sv
module bch8_fixer
    import bch8_fix_pkg::*;
#(
    parameter int SECTOR_BYTES   = DEF_SECTOR_BYTES,
    parameter int PARITY_NIBBLES = DEF_PARITY_NIBBLES,
    parameter int MAX_ERRS       = DEF_MAX_ERRS,
    parameter int LOC_W          = DEF_LOC_W,
    parameter int CNT_W          = DEF_CNT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [PARITY_NIBBLES*4-1:0] res_bytes,
    input  logic [PARITY_NIBBLES*4+7:0] spare_ecc,
    input  logic [CNT_W-1:0]            loc_count,
    input  logic [MAX_ERRS*LOC_W-1:0]   loc_list,
    input  logic                        loc_fail,
    output logic [PARITY_NIBBLES*4+7:0] calc_bytes,
    output logic [PARITY_NIBBLES*4-1:0] syndrome,
    output logic                        busy,
    output logic                        done,
    output logic                        ok,
    output logic [CNT_W-1:0]            fix_count,
    output logic [$clog2(SECTOR_BYTES)-1:0] buf_addr,
    output logic                        buf_rd_en,
    input  logic [7:0]                  buf_rdata,
    output logic                        buf_wr_en,
    output logic [7:0]                  buf_wdata
);
    localparam int PARITY_BITS = PARITY_NIBBLES * 4;
    localparam int SYN_BYTES   = PARITY_BITS / 8;
    localparam int ECC_BYTES   = SYN_BYTES + 1;
    localparam int DATA_BITS   = SECTOR_BYTES * 8;
    localparam int ADDR_W      = $clog2(SECTOR_BYTES);
    localparam int IDX_W       = $clog2(MAX_ERRS);

    fix_state_t state, state_nx;

    logic [MAX_ERRS*LOC_W-1:0] locs_q;
    logic [CNT_W-1:0]          cnt_q, idx_q, fix_q;
    logic [ADDR_W-1:0]         addr_q;
    logic [7:0]                mask_q;
    logic                      ok_q;

    logic                      erased, too_many, map_hit, at_end;
    logic [ADDR_W-1:0]         map_addr;
    logic [7:0]                map_mask;
    logic [LOC_W-1:0]          loc_arr [MAX_ERRS];

    bch8_result_order #(.SYN_BYTES(SYN_BYTES), .ECC_BYTES(ECC_BYTES)) u_order (
        .res_bytes (res_bytes),
        .calc_bytes(calc_bytes),
        .syndrome  (syndrome)
    );

    bch8_erase_detect #(.ECC_BYTES(ECC_BYTES)) u_erase (
        .spare_ecc(spare_ecc),
        .erased   (erased)
    );

    for (genvar g = 0; g < MAX_ERRS; g++) begin : g_loc
        assign loc_arr[g] = locs_q[g*LOC_W +: LOC_W];
    end

    bch8_loc_map #(
        .LOC_W(LOC_W), .PARITY_BITS(PARITY_BITS),
        .DATA_BITS(DATA_BITS), .ADDR_W(ADDR_W)
    ) u_map (
        .loc (loc_arr[idx_q[IDX_W-1:0]]),
        .hit (map_hit),
        .addr(map_addr),
        .mask(map_mask)
    );

    assign too_many = loc_count > CNT_W'(MAX_ERRS);
    assign at_end   = idx_q == cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions E1..E3, T1..T7
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) begin
                          if (erased || loc_fail || too_many) state_nx = ST_DONE;
                          else                                state_nx = ST_PICK;
                      end
            ST_PICK:  if (at_end)       state_nx = ST_DONE;
                      else if (map_hit) state_nx = ST_READ;
            ST_READ:  state_nx = ST_WRITE;
            ST_WRITE: state_nx = ST_PICK;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Run datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locs_q <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            fix_q  <= '0;
            addr_q <= '0;
            mask_q <= '0;
            ok_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    locs_q <= loc_list;
                    cnt_q  <= loc_count;
                    idx_q  <= '0;
                    fix_q  <= '0;
                    ok_q   <= erased || !(loc_fail || too_many);
                end
                ST_PICK: if (!at_end) begin
                    if (map_hit) begin
                        addr_q <= map_addr;
                        mask_q <= map_mask;
                    end else begin
                        idx_q <= idx_q + CNT_W'(1);
                    end
                end
                ST_WRITE: begin
                    idx_q <= idx_q + CNT_W'(1);
                    fix_q <= fix_q + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = state != ST_IDLE;
        done      = state == ST_DONE;
        buf_rd_en = state == ST_READ;
        buf_wr_en = state == ST_WRITE;
        buf_addr  = addr_q;
        buf_wdata = buf_rdata ^ mask_q;
        ok        = ok_q;
        fix_count = fix_q;
    end
endmodule

// File: rtl/bch8_fix_chk.sv
module bch8_fix_chk #(
    parameter int SECTOR_BYTES   = 512,
    parameter int PARITY_NIBBLES = 26,
    parameter int MAX_ERRS       = 8,
    parameter int CNT_W          = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start,
    input logic                        busy,
    input logic                        done,
    input logic                        ok,
    input logic [CNT_W-1:0]            fix_count,
    input logic [PARITY_NIBBLES*4+7:0] spare_ecc,
    input logic                        loc_fail,
    input logic                        buf_rd_en,
    input logic                        buf_wr_en,
    input logic [$clog2(SECTOR_BYTES)-1:0] buf_addr
);
    a_r7_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> buf_wr_en && $stable(buf_addr));

    a_r7_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $past(buf_rd_en));

    a_r9_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en && buf_wr_en));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_erased_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (&spare_ecc)) |=> done && ok && fix_count == '0);

    a_r4_fail_no_fix: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !(&spare_ecc) && loc_fail) |=> done && !ok && !buf_wr_en);

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fix_count <= CNT_W'(MAX_ERRS));
endmodule

bind bch8_fixer bch8_fix_chk #(
    .SECTOR_BYTES(SECTOR_BYTES), .PARITY_NIBBLES(PARITY_NIBBLES),
    .MAX_ERRS(MAX_ERRS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ok(ok), .fix_count(fix_count), .spare_ecc(spare_ecc), .loc_fail(loc_fail),
    .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en), .buf_addr(buf_addr)
);

// File: tb/bch8_fixer_bench.sv
`timescale 1ns/1ps
module bch8_fixer_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [103:0] res_bytes = '0;
    logic [111:0] spare_ecc = '0;
    logic [3:0]   loc_count = '0;
    logic [103:0] loc_list = '0;
    logic         loc_fail = 1'b0;
    logic [111:0] calc_bytes;
    logic [103:0] syndrome;
    logic         busy, done, ok;
    logic [3:0]   fix_count;
    logic [8:0]   buf_addr;
    logic         buf_rd_en, buf_wr_en;
    logic [7:0]   buf_rdata = '0;
    logic [7:0]   buf_wdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] mem     [512];
    logic [7:0] ref_mem [512];
    int exp_addr [$];
    int exp_mask [$];

    always #2 clk = ~clk;

    bch8_fixer u_bch8_fixer (
        .clk(clk), .rst_n(rst_n), .start(start), .res_bytes(res_bytes),
        .spare_ecc(spare_ecc), .loc_count(loc_count), .loc_list(loc_list),
        .loc_fail(loc_fail), .calc_bytes(calc_bytes), .syndrome(syndrome),
        .busy(busy), .done(done), .ok(ok), .fix_count(fix_count),
        .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata),
        .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata)
    );

    // Sector buffer model: one-cycle read latency
    always @(posedge clk) begin
        if (buf_rd_en) buf_rdata <= mem[buf_addr];
        if (buf_wr_en) mem[buf_addr] <= buf_wdata;
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-clock write comparison against the behavioural model (R6, R7)
    always @(negedge clk) begin
        if (rst_n && !finished && buf_wr_en) begin
            if (exp_addr.size() == 0) begin
                chk(0, "R4", "write with none expected", buf_addr, 0);
            end else begin
                int a, m;
                a = exp_addr.pop_front();
                m = exp_mask.pop_front();
                chk(buf_addr == 9'(a), "R6", "write address", buf_addr, a);
                chk(buf_wdata == (ref_mem[a] ^ 8'(m)), "R7", "write data",
                    buf_wdata, ref_mem[a] ^ 8'(m));
                ref_mem[a] = ref_mem[a] ^ 8'(m);
            end
        end
    end

    function automatic logic [103:0] pack8(input int l0, l1, l2, l3, l4, l5, l6, l7);
        pack8 = {13'(l7), 13'(l6), 13'(l5), 13'(l4), 13'(l3), 13'(l2), 13'(l1), 13'(l0)};
    endfunction

    task automatic run_case(input string req, input logic [3:0] cnt, input logic [103:0] locs,
                            input logic fail, input logic [111:0] spare, input bit poke);
        int fixes = 0, skips = 0, exp_cycles, cycles;
        bit exp_ok;
        if (&spare) begin
            exp_cycles = 1; exp_ok = 1;
        end else if (fail || cnt > 8) begin
            exp_cycles = 1; exp_ok = 0;
        end else begin
            for (int k = 0; k < int'(cnt); k++) begin
                int p, l;
                p = int'(locs[k*13 +: 13]);
                if (p >= 104 && p <= 4199) begin
                    l = p - 104;
                    exp_addr.push_back((4095 - l) / 8);
                    exp_mask.push_back(1 << (l % 8));
                    fixes++;
                end else begin
                    skips++;
                end
            end
            exp_cycles = 2 + skips + 3 * fixes;
            exp_ok = 1;
        end
        spare_ecc = spare; loc_count = cnt; loc_list = locs; loc_fail = fail;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        chk(busy == 1'b1, "R9", "busy after start", busy, 1);
        if (poke) begin
            start = 1'b1; loc_list = '1; loc_count = 4'd1;
        end
        while (!done && cycles < 1000) begin
            @(negedge clk);
            cycles++;
            start = 1'b0;
        end
        chk(cycles == exp_cycles, req, "done latency", cycles, exp_cycles);
        chk(ok == exp_ok, req, "ok status", ok, exp_ok);
        chk(fix_count == 4'(fixes), "R8", "fix count", fix_count, fixes);
        chk(exp_addr.size() == 0, "R7", "writes missing", exp_addr.size(), 0);
        exp_addr.delete(); exp_mask.delete();
        begin
            int bad = 0;
            for (int i = 0; i < 512; i++) if (mem[i] !== ref_mem[i]) bad++;
            chk(bad == 0, "R5", "sector bytes differing", bad, 0);
        end
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9", "done pulse ends", {done, busy}, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual expired expected finish");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [111:0] exp_calc;
        logic [31:0]  r0, r1, r2;
        logic [7:0]   r3;
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({busy, done, ok, buf_rd_en, buf_wr_en} == 5'b0 && fix_count == 4'd0,
            "R10", "reset outputs", {busy, done, ok, buf_rd_en, buf_wr_en, fix_count}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2: byte ordering
        r0 = 32'h1122_3344; r1 = 32'h5566_7788; r2 = 32'h99AA_BBCC; r3 = 8'hDD;
        res_bytes = {r3, r2, r1, r0};
        exp_calc = {8'h00, r0[7:0], r0[15:8], r0[23:16], r0[31:24],
                    r1[7:0], r1[15:8], r1[23:16], r1[31:24],
                    r2[7:0], r2[15:8], r2[23:16], r2[31:24], r3};
        #1;
        chk(calc_bytes == exp_calc, "R1", "calc bytes low", calc_bytes[63:0], exp_calc[63:0]);
        begin
            int bad = 0;
            for (int i = 0; i < 13; i++)
                if (syndrome[8*i +: 8] !== exp_calc[8*(12-i) +: 8]) bad++;
            chk(bad == 0, "R2", "syndrome bytes reversed", bad, 0);
        end
        res_bytes = 104'h0F_EDCB_A987_6543_2100_FFEE_DDCC;
        #1;
        chk(calc_bytes[7:0] == 8'h0F && calc_bytes[111:104] == 8'h00 && calc_bytes[103:96] == 8'hCC,
            "R1", "calc edge bytes", calc_bytes[111:96], 0);
        chk(syndrome[103:96] == 8'h0F, "R2", "syndrome top byte", syndrome[103:96], 8'h0F);
        @(negedge clk);

        // R5, R6: window edges, mixed skips
        run_case("R8", 4'd6, pack8(0, 103, 104, 4199, 4200, 200, 0, 0), 1'b0, '0, 0);
        // R7: two flips in one byte; entry beyond count unused
        run_case("R7", 4'd2, pack8(105, 106, 1000, 0, 0, 0, 0, 0), 1'b0, 112'h5, 0);
        // R9: full list, start and inputs disturbed mid-run
        run_case("R9", 4'd8, pack8(300, 500, 777, 1234, 2048, 3000, 4000, 4100), 1'b0, '0, 1);
        // R8: empty list
        run_case("R8", 4'd0, '0, 1'b0, '0, 0);
        // R4: locator failure and count over eight
        run_case("R4", 4'd2, pack8(300, 400, 0, 0, 0, 0, 0, 0), 1'b1, '0, 0);
        run_case("R4", 4'd9, pack8(300, 400, 500, 600, 700, 800, 900, 1000), 1'b0, '0, 0);
        // R3: erased sector, even with failure flag set
        run_case("R3", 4'd3, pack8(300, 400, 500, 0, 0, 0, 0, 0), 1'b0, '1, 0);
        run_case("R3", 4'd1, pack8(300, 0, 0, 0, 0, 0, 0, 0), 1'b1, '1, 0);
        // R3: one byte not 0xFF means not erased
        run_case("R6", 4'd1, pack8(150, 0, 0, 0, 0, 0, 0, 0), 1'b0, {8'hFE, {13{8'hFF}}}, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule